// File: doc/BRIEF.md
# Video Memory Dirty-Page Tracker

This block keeps one flag per 4096-byte page of a 4 MiB video memory and records which pages have been written since the last display refresh. Every byte write seen on the memory side sets the flag of the page it lands in. In planar latched-write mode the incoming address counts 32-bit plane words, so it is scaled by four to give a byte address before the page is chosen.

During a refresh, the scanout engine presents each scanline as a start address and a byte width and gets a same-cycle answer: redraw or skip. The answer comes from the flags of the line's first and last pages. When those pages are two or more apart, the flag of the page just after the first page is also read. A force input makes the answer true regardless of the flags. The tracker also keeps the lowest and highest page touched by the lines that got a true answer since the last start-of-frame pulse.

At the end of a frame, a clear command starts a sweep that zeroes the flags over that page span, one page per cycle. The sweep is driven by a two-state machine. IDLE waits for a clear command. The transition IDLE to SWEEP is taken on a clear command when at least one line got a true answer in the current frame; a clear command with no such line stays in IDLE. SWEEP clears the page under its pointer on every cycle and steps the pointer, staying in SWEEP until the highest page has been cleared. The transition SWEEP to IDLE follows that last page.

Top module: `dpt_dirty_tracker`

## Requirements
- R1: After reset every page flag is clean, no line range is recorded, and `clr_busy` is low.
- R2: A cycle with `wr_en` high and `wr_planar` low sets the flag of page `wr_addr[21:12]` at the next clock edge. Flags never become dirty without a write.
- R3: With `wr_planar` high, the page is taken from the address multiplied by four, that is page `wr_addr[19:10]`; the page `wr_addr[21:12]` is not marked unless it is that same page.
- R4: `q_hit` is combinational from the query inputs. It is the OR of `q_full`, the flag of page `q_addr[21:12]` and the flag of the page holding byte `q_addr + q_width - 1` (a width of 0 is treated as 1).
- R5: When the last page number exceeds the first page number by 2 or more, the flag of the first page plus one is also ORed into `q_hit`. No other page between them is consulted.
- R6: The tracker records the lowest and highest page among the first and last pages of every query that had `q_valid` and `q_hit` high since the last `frame_start` pulse. `frame_start` discards the range; a query in the same cycle as `frame_start` counts toward the new frame.
- R7: `clr_req` in IDLE with a recorded range enters SWEEP. `clr_busy` is then high for exactly (highest − lowest + 1) cycles, starting the next cycle. At the end every flag in the range is clean and every flag outside it is unchanged.
- R8: `clr_req` with no recorded range has no effect: `clr_busy` stays low and no flag changes.
- R9: If a write and the sweep hit the same page in the same cycle, that page ends dirty.
- R10: `clr_req` while `clr_busy` is high is ignored; the sweep length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe from the memory port |
| wr_addr | input | 22 | Write address (byte address, or plane word address when planar) |
| wr_planar | input | 1 | Planar latched-write mode: scale address by four |
| frame_start | input | 1 | Start-of-frame pulse, discards the recorded page range |
| q_valid | input | 1 | Scanline query present this cycle |
| q_addr | input | 22 | Byte address of the first byte of the scanline |
| q_width | input | 16 | Scanline width in bytes |
| q_full | input | 1 | Force the query answer to true |
| q_hit | output | 1 | Query answer: the line needs redrawing |
| clr_req | input | 1 | End-of-frame clear command |
| clr_busy | output | 1 | Clear sweep in progress |

## Verification
A flag that is wrongly set or cleared shows at `q_hit` on the first query that reads that page. This appears in the same cycle, because the answer is combinational from the flag store. A corrupted page range shows as a `clr_busy` pulse of the wrong length, or at the wrong time, right after the next clear command. It can also show later as a page that answers dirty or clean against expectation. The bench mirrors the flags, range and sweep pointer in a behavioural model and compares `q_hit` and `clr_busy` on every clock. Any such divergence is therefore caught at the first cycle it becomes visible.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    localparam int DPT_ADDR_W     = 22;
    localparam int DPT_PAGE_SHIFT = 12;
    localparam int DPT_LW_W       = 16;

    typedef enum logic [0:0] {
        SWP_IDLE = 1'b0,
        SWP_RUN  = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/dpt_page_map.sv
module dpt_page_map #(
    parameter int ADDR_W     = dpt_pkg::DPT_ADDR_W,
    parameter int PAGE_SHIFT = dpt_pkg::DPT_PAGE_SHIFT,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_planar,
    output logic [PAGE_W-1:0] wr_page
);
    logic [ADDR_W-1:0] byte_addr;

    // plane word address: four bytes per word, scale before paging
    always_comb begin
        if (wr_planar)
            byte_addr = {wr_addr[ADDR_W-3:0], 2'b00};
        else
            byte_addr = wr_addr;
        wr_page = byte_addr[ADDR_W-1:PAGE_SHIFT];
    end
endmodule

// File: rtl/dpt_line_query.sv
module dpt_line_query #(
    parameter int ADDR_W     = dpt_pkg::DPT_ADDR_W,
    parameter int PAGE_SHIFT = dpt_pkg::DPT_PAGE_SHIFT,
    parameter int LW_W       = dpt_pkg::DPT_LW_W,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [LW_W-1:0]   q_width,
    output logic [PAGE_W-1:0] pg_first,
    output logic [PAGE_W-1:0] pg_last,
    output logic [PAGE_W-1:0] pg_mid,
    output logic              use_mid
);
    logic [LW_W-1:0]   span;
    logic [ADDR_W-1:0] last_addr;
    logic [PAGE_W-1:0] pg_diff;

    always_comb begin
        span      = (q_width == '0) ? '0 : q_width - {{(LW_W-1){1'b0}}, 1'b1};
        last_addr = q_addr + {{(ADDR_W-LW_W){1'b0}}, span};
        pg_first  = q_addr[ADDR_W-1:PAGE_SHIFT];
        pg_last   = last_addr[ADDR_W-1:PAGE_SHIFT];
        pg_diff   = pg_last - pg_first;
        use_mid   = (pg_diff > PAGE_W'(1));
        pg_mid    = pg_first + PAGE_W'(1);
    end

    // R5
    always_comb begin
        if (use_mid) begin
            mid_inside_chk: assert (pg_mid != pg_last && pg_mid != pg_first);
        end
    end
endmodule

// File: rtl/dpt_bounds.sv
module dpt_bounds #(
    parameter int PAGE_W = dpt_pkg::DPT_ADDR_W - dpt_pkg::DPT_PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              hit_valid,
    input  logic [PAGE_W-1:0] pg_a,
    input  logic [PAGE_W-1:0] pg_b,
    output logic              any_q,
    output logic [PAGE_W-1:0] lo_q,
    output logic [PAGE_W-1:0] hi_q
);
    logic              base_any;
    logic [PAGE_W-1:0] in_lo, in_hi;

    always_comb begin
        base_any = any_q & ~frame_start;
        in_lo    = (pg_a <= pg_b) ? pg_a : pg_b;
        in_hi    = (pg_a <= pg_b) ? pg_b : pg_a;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            any_q <= base_any | hit_valid;
            if (hit_valid) begin
                if (!base_any) begin
                    lo_q <= in_lo;
                    hi_q <= in_hi;
                end else begin
                    if (in_lo < lo_q) lo_q <= in_lo;
                    if (in_hi > hi_q) hi_q <= in_hi;
                end
            end
        end
    end

    // R6
    range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_q |-> (lo_q <= hi_q));

    // R6
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !hit_valid) |=> !any_q);
endmodule

// File: rtl/dpt_clear_fsm.sv
module dpt_clear_fsm #(
    parameter int PAGE_W = dpt_pkg::DPT_ADDR_W - dpt_pkg::DPT_PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic              any_range,
    input  logic [PAGE_W-1:0] range_lo,
    input  logic [PAGE_W-1:0] range_hi,
    output logic              busy,
    output logic              sweep_en,
    output logic [PAGE_W-1:0] sweep_pg
);
    import dpt_pkg::*;

    sweep_state_e      state_q, state_d;
    logic [PAGE_W-1:0] ptr_q, end_q;
    logic              go, last;

    always_comb begin
        go      = clr_req & any_range;
        last    = (ptr_q == end_q);
        state_d = state_q;
        unique case (state_q)
            SWP_IDLE: if (go)   state_d = SWP_RUN;
            SWP_RUN:  if (last) state_d = SWP_IDLE;
            default:            state_d = SWP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SWP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            end_q <= '0;
        end else if (state_q == SWP_IDLE) begin
            if (go) begin
                ptr_q <= range_lo;
                end_q <= range_hi;
            end
        end else if (!last) begin
            ptr_q <= ptr_q + PAGE_W'(1);
        end
    end

    always_comb begin
        busy     = (state_q == SWP_RUN);
        sweep_en = (state_q == SWP_RUN);
        sweep_pg = ptr_q;
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SWP_IDLE && !(clr_req && any_range)) |=> (state_q == SWP_IDLE));

    // R7
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SWP_RUN && !last) |=> (state_q == SWP_RUN && ptr_q == $past(ptr_q) + PAGE_W'(1)));

    // R10
    req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SWP_RUN && !last) |=> $stable(end_q));
endmodule

// File: rtl/dpt_dirty_tracker.sv
module dpt_dirty_tracker #(
    parameter int ADDR_W     = dpt_pkg::DPT_ADDR_W,
    parameter int PAGE_SHIFT = dpt_pkg::DPT_PAGE_SHIFT,
    parameter int LW_W       = dpt_pkg::DPT_LW_W,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
    localparam int NUM_PAGES = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_planar,
    input  logic              frame_start,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [LW_W-1:0]   q_width,
    input  logic              q_full,
    output logic              q_hit,
    input  logic              clr_req,
    output logic              clr_busy
);
    logic [NUM_PAGES-1:0] dirty_q;
    logic [PAGE_W-1:0]    wr_page, pg_first, pg_last, pg_mid, range_lo, range_hi, sweep_pg;
    logic                 use_mid, any_range, sweep_en;

    dpt_page_map #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_map (
        .wr_addr   (wr_addr),
        .wr_planar (wr_planar),
        .wr_page   (wr_page)
    );

    dpt_line_query #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .LW_W(LW_W)) u_query (
        .q_addr   (q_addr),
        .q_width  (q_width),
        .pg_first (pg_first),
        .pg_last  (pg_last),
        .pg_mid   (pg_mid),
        .use_mid  (use_mid)
    );

    always_comb begin
        q_hit = q_full | dirty_q[pg_first] | dirty_q[pg_last] | (use_mid & dirty_q[pg_mid]);
    end

    dpt_bounds #(.PAGE_W(PAGE_W)) u_bounds (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .hit_valid   (q_valid & q_hit),
        .pg_a        (pg_first),
        .pg_b        (pg_last),
        .any_q       (any_range),
        .lo_q        (range_lo),
        .hi_q        (range_hi)
    );

    dpt_clear_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req   (clr_req),
        .any_range (any_range),
        .range_lo  (range_lo),
        .range_hi  (range_hi),
        .busy      (clr_busy),
        .sweep_en  (sweep_en),
        .sweep_pg  (sweep_pg)
    );

    // sweep clear first, write second: a same-page write wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else begin
            if (sweep_en) dirty_q[sweep_pg] <= 1'b0;
            if (wr_en)    dirty_q[wr_page]  <= 1'b1;
        end
    end

    // R2
    write_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dirty_q[$past(wr_page)]);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($countones(dirty_q) <= $past($countones(dirty_q))));

    // R7
    sweep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !(wr_en && wr_page == sweep_pg)) |=> !dirty_q[$past(sweep_pg)]);

    // R4
    full_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_full) |-> q_hit);
endmodule

// File: tb/sim_dpt_dirty_tracker.sv
module sim_dpt_dirty_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_planar, frame_start, q_valid, q_full, clr_req;
    logic [21:0] wr_addr, q_addr;
    logic [15:0] q_width;
    logic        q_hit, clr_busy;

    int checks = 0;
    int errors = 0;

    bit m_dirty [1024];
    int m_any, m_lo, m_hi, m_busy, m_ptr, m_end;

    always #5 clk = ~clk;

    dpt_dirty_tracker u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_planar(wr_planar), .frame_start(frame_start), .q_valid(q_valid),
        .q_addr(q_addr), .q_width(q_width), .q_full(q_full), .q_hit(q_hit),
        .clr_req(clr_req), .clr_busy(clr_busy)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pfirst(int a);
        return (a >> 12) & 1023;
    endfunction

    function automatic int plast(int a, int w);
        return ((a + ((w == 0) ? 0 : w - 1)) >> 12) & 1023;
    endfunction

    function automatic int m_hit(int a, int w, int f);
        int p0 = pfirst(a);
        int p1 = plast(a, w);
        int h  = f | m_dirty[p0] | m_dirty[p1];
        if (p1 - p0 > 1) h = h | m_dirty[p0 + 1];
        return h;
    endfunction

    task automatic set_idle();
        wr_en = 0; wr_addr = '0; wr_planar = 0; frame_start = 0;
        q_valid = 0; q_addr = '0; q_width = '0; q_full = 0; clr_req = 0;
    endtask

    // compare before the edge, advance the model at the edge, idle inputs after
    task automatic tick();
        int hq, p0, p1, wp;
        #1;
        if (q_valid) check("R4 q_hit vs model", int'(q_hit), m_hit(q_addr, q_width, q_full));
        check("R7 clr_busy vs model", int'(clr_busy), m_busy);
        @(posedge clk);
        hq = q_valid ? m_hit(q_addr, q_width, q_full) : 0;
        p0 = pfirst(q_addr);
        p1 = plast(q_addr, q_width);
        if (m_busy != 0) begin
            m_dirty[m_ptr] = 0;
            if (m_ptr == m_end) m_busy = 0;
            else m_ptr++;
        end else if (clr_req && m_any != 0) begin
            m_busy = 1; m_ptr = m_lo; m_end = m_hi;
        end
        if (wr_en) begin
            wp = wr_planar ? ((int'(wr_addr) << 2) >> 12) & 1023 : (int'(wr_addr) >> 12) & 1023;
            m_dirty[wp] = 1;
        end
        if (frame_start) m_any = 0;
        if (hq != 0) begin
            if (m_any == 0) begin
                m_lo = p0; m_hi = p1; m_any = 1;
            end else begin
                if (p0 < m_lo) m_lo = p0;
                if (p1 > m_hi) m_hi = p1;
            end
        end
        @(negedge clk);
        set_idle();
    endtask

    task automatic write(int a, int planar);
        wr_en = 1; wr_addr = 22'(a); wr_planar = planar[0];
        tick();
    endtask

    task automatic query(int a, int w, int f, int exp, string tag);
        q_valid = 1; q_addr = 22'(a); q_width = 16'(w); q_full = f[0];
        #1;
        check(tag, int'(q_hit), exp);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        set_idle();
        rst_n = 0;
        m_any = 0; m_lo = 0; m_hi = 0; m_busy = 0; m_ptr = 0; m_end = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1 check("R1 busy after reset", int'(clr_busy), 0);
        query(0, 640, 0, 0, "R1 clean page 0");
        query(22'h3FF000, 16, 0, 0, "R1 clean top page");

        // R2 linear write marks page 3
        write(22'h3005, 0);
        query(22'h3000, 16, 0, 1, "R2 page 3 dirty");
        query(22'h2000, 16, 0, 0, "R2 page 2 clean");

        // R3 planar write 0x1400 lands in page 5, not page 1
        write(22'h1400, 1);
        query(22'h5000, 1, 0, 1, "R3 planar page 5 dirty");
        query(22'h1000, 16, 0, 0, "R3 page 1 clean");

        // R4 force input and last-byte page
        query(22'h30000, 16, 1, 1, "R4 full forces hit");
        query(22'h6FF0, 16, 0, 0, "R4 line inside page 6");
        write(22'h7000, 0);
        query(22'h6FF0, 32, 0, 1, "R4 last byte page 7");
        query(22'h6FF0, 0, 0, 0, "R4 width 0 as 1");

        // R5 middle page
        write(22'hA000, 0);
        query(22'h9F00, 16'h1200, 0, 1, "R5 mid page 10");
        write(22'h15000, 0);
        query(22'h13F00, 16'h3100, 0, 0, "R5 page 21 not consulted");

        // R6/R7/R9/R10 range and sweep
        frame_start = 1; tick();
        query(22'h3000, 16, 0, 1, "R6 hit page 3");
        query(22'h9F00, 16'h1200, 0, 1, "R6 hit pages 9-11");
        query(22'h20000, 16, 0, 0, "R6 clean page 32 not in range");
        clr_req = 1; tick();
        cnt = 0;
        while (m_busy != 0) begin
            cnt++;
            if (m_ptr == 7) begin wr_en = 1; wr_addr = 22'h7000; end
            clr_req = (cnt == 1);
            tick();
        end
        check("R7 sweep length 3..11", cnt, 9);
        check("R10 busy low after sweep", int'(clr_busy), 0);
        query(22'h3000, 16, 0, 0, "R7 page 3 cleared");
        query(22'h5000, 16, 0, 0, "R7 page 5 cleared");
        query(22'hA000, 16, 0, 0, "R7 page 10 cleared");
        query(22'h7000, 16, 0, 1, "R9 page 7 kept by write");
        query(22'h15000, 16, 0, 1, "R7 page 21 outside range");

        // R6 frame_start discards, R8 no range no effect
        frame_start = 1; tick();
        query(22'h15000, 16, 0, 1, "R6 hit page 21");
        frame_start = 1; tick();
        clr_req = 1; tick();
        #1 check("R8 no sweep after discard", int'(clr_busy), 0);
        clr_req = 1; tick();
        #1 check("R8 no sweep without range", int'(clr_busy), 0);
        query(22'h15000, 16, 0, 1, "R8 page 21 untouched");

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            wr_en       = ($urandom_range(0, 2) == 0);
            wr_addr     = 22'($urandom_range(0, 22'h3FFFFF));
            wr_planar   = ($urandom_range(0, 3) == 0);
            q_valid     = ($urandom_range(0, 1) == 0);
            q_addr      = 22'($urandom_range(0, 22'h2FFFFF));
            q_width     = 16'($urandom_range(0, 16'h4000));
            q_full      = ($urandom_range(0, 7) == 0);
            frame_start = ($urandom_range(0, 19) == 0);
            clr_req     = ($urandom_range(0, 14) == 0);
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule